// File: doc/BRIEF.md
# Completion Record Write Controller

This block sits at the tail of a descriptor engine. When a descriptor finishes or aborts, the engine presents the descriptor's completion attributes in one cycle. These are the request flag, the address-valid flag, the completion address and whether the operation yields a result. The engine also presents the outcome, the result byte, the count of bytes completed and the faulting address. The controller then decides among three actions: write a 32-byte completion record to memory, raise a pulse toward the global software error register, or do nothing.

A record is written whenever software asked for one. It is also written without a request when the operation faulted or failed, so that software always learns of trouble when it gave a usable address. When no usable address exists, an error or fault goes to the software error report instead. The controller assembles the record image and issues a single write on a valid/ready handshake. It holds that request steady until it is accepted and refuses new completions in the meantime.

Top module: `cmpl_rec_writer`

## Requirements
- R1: A completion with outcome success (outcome code 0), request flag 1, address-valid flag 1 and an address whose low 5 bits are zero produces exactly one write to that address with status byte 0x01.
- R2: A successful completion with request flag 0 and no result-producing operation produces no write and no error report.
- R3: With request flag 0, address-valid 1 and an aligned address, outcome page fault (code 1) writes a record with status 0x03, and outcome error (code 2 or 3) writes a record with status 0x04.
- R4: With address-valid 0, a fault or error outcome produces no write and a one-cycle error report whose code equals the record status the record would have carried (0x03 or 0x04). A success outcome with address-valid 0 produces neither a write nor a report, even when request flag is 1.
- R5: A result-producing operation whose request flag or address-valid flag is 0 is treated as an error with status 0x05. It is written as a record if the address is valid and aligned, and reported with code 0x05 otherwise.
- R6: When address-valid is 1 and any of the low 5 address bits is set, no write occurs and an error report with code 0x06 is raised, whatever the outcome and flags.
- R7: The record layout is as follows. Byte 0 holds the status. Byte 1 holds the result, only for status 0x01 of a result-producing operation, and is zero otherwise. Bytes 4 to 7 hold bytes completed (little-endian). Bytes 8 to 15 hold the fault address, only for status 0x03, and are zero otherwise. All other bytes are zero.
- R8: While a write is pending, the address and data stay stable until the memory side accepts them, and completion ready stays low, so no completion is taken.
- R9: After reset the write request and error report are inactive and completion ready is high.
- R10: The write request or error report appears in the cycle after the completion is accepted. The report lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_valid | input | 1 | Completion presented |
| cmp_ready | output | 1 | Completion can be taken this cycle |
| cmp_req_rec | input | 1 | Software asked for a record |
| cmp_addr_ok | input | 1 | Completion address field is meaningful |
| cmp_addr | input | ADDR_W | Completion record address |
| cmp_has_result | input | 1 | Operation yields a result |
| cmp_outcome | input | 2 | 0 success, 1 page fault, 2/3 error |
| cmp_result | input | 8 | Result byte |
| cmp_bytes_done | input | 32 | Bytes processed before stop |
| cmp_fault_addr | input | ADDR_W | Faulting address |
| wr_valid | output | 1 | Record write request |
| wr_ready | input | 1 | Memory side accepts the write |
| wr_addr | output | ADDR_W | Record address |
| wr_data | output | 8*REC_BYTES | Record image, byte 0 in bits 7:0 |
| swerr_valid | output | 1 | One-cycle software error report |
| swerr_code | output | 8 | Status code of the report |

## Verification
A wrong decision shows one cycle after acceptance. It appears as a write where a report was due, a report where a write was due, or a status byte that differs from the one the flags and outcome call for. A corrupted or unstable holding register shows during a stalled write, as address or data changing between cycles while ready is low. A broken back-pressure path shows as a report or second write appearing during that stall. Field placement errors appear at once in the record image compared byte for byte.

// File: rtl/crw_pkg.sv
// Package: shared outcome encoding, status codes and action type for the
// completion record writer. Assumes outcome codes 2 and 3 both mean error.
package crw_pkg;
    localparam logic [1:0] OC_OK    = 2'd0;
    localparam logic [1:0] OC_FAULT = 2'd1;

    localparam logic [7:0] ST_OK        = 8'h01;
    localparam logic [7:0] ST_FAULT     = 8'h03;
    localparam logic [7:0] ST_ERROR     = 8'h04;
    localparam logic [7:0] ST_BAD_FLAGS = 8'h05;
    localparam logic [7:0] ST_MISALIGN  = 8'h06;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_WRITE = 2'd1,
        ACT_SWERR = 2'd2
    } action_e;

    typedef struct packed {
        action_e    act;
        logic [7:0] code;
    } decision_t;
endpackage

// File: rtl/crw_decide.sv
// Decision logic: maps flags, alignment and outcome to an action and a
// status code. Purely combinational; assumes inputs are valid when used.
module crw_decide
    import crw_pkg::*;
#(
    parameter int ALIGN_BITS = 5
) (
    input  logic                  req_rec,
    input  logic                  addr_ok,
    input  logic [ALIGN_BITS-1:0] addr_low,
    input  logic                  has_result,
    input  logic [1:0]            outcome,
    output decision_t             dec
);
    logic       misaligned;
    logic       bad_flags;
    logic       failed;
    logic [7:0] status;

    // Classify the completion into a status code.
    always_comb begin
        misaligned = addr_ok && (addr_low != '0);
        bad_flags  = has_result && !(req_rec && addr_ok);
        if (bad_flags)                status = ST_BAD_FLAGS;
        else if (outcome == OC_OK)    status = ST_OK;
        else if (outcome == OC_FAULT) status = ST_FAULT;
        else                          status = ST_ERROR;
        failed = (status != ST_OK);
    end

    // Choose between memory write, error report or nothing.
    always_comb begin
        dec.act  = ACT_NONE;
        dec.code = status;
        if (misaligned) begin
            dec.act  = ACT_SWERR;
            dec.code = ST_MISALIGN;
        end else if (addr_ok && (req_rec || failed)) begin
            dec.act = ACT_WRITE;
        end else if (!addr_ok && failed) begin
            dec.act = ACT_SWERR;
        end
    end
endmodule

// File: rtl/crw_pack.sv
// Record assembly: builds the record image from status and completion data.
// Byte 0 lands in bits 7:0. Assumes REC_BYTES >= 16.
module crw_pack
    import crw_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int REC_BYTES = 32,
    localparam int DATA_W   = 8 * REC_BYTES
) (
    input  logic [7:0]        status,
    input  logic              has_result,
    input  logic [7:0]        result,
    input  logic [31:0]       bytes_done,
    input  logic [ADDR_W-1:0] fault_addr,
    output logic [DATA_W-1:0] image
);
    localparam int FA_LSB = 64;

    // Place each field and clear the rest.
    always_comb begin
        image        = '0;
        image[7:0]   = status;
        image[15:8]  = (status == ST_OK && has_result) ? result : 8'h00;
        image[63:32] = bytes_done;
        if (status == ST_FAULT)
            image[FA_LSB +: ADDR_W] = fault_addr;
    end
endmodule

// File: rtl/crw_out.sv
// Output stage: holds a write request until accepted and issues one-cycle
// error reports. Assumes load is only asserted when no write is pending.
module crw_out
    import crw_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  decision_t         dec,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] image,
    input  logic              wr_ready,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              swerr_valid,
    output logic [7:0]        swerr_code
);
    // Write request register: set on load, cleared on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else if (load && dec.act == ACT_WRITE) begin
            wr_valid <= 1'b1;
            wr_addr  <= addr;
            wr_data  <= image;
        end else if (wr_valid && wr_ready) begin
            wr_valid <= 1'b0;
        end
    end

    // Error report pulse: one cycle per reported completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swerr_valid <= 1'b0;
            swerr_code  <= 8'h00;
        end else begin
            swerr_valid <= load && dec.act == ACT_SWERR;
            if (load && dec.act == ACT_SWERR)
                swerr_code <= dec.code;
        end
    end
endmodule

// File: rtl/cmpl_rec_writer.sv
// Top: accepts one completion per free cycle, decides, packs and issues the
// record write or error report. Ready is low while a write is pending.
module cmpl_rec_writer
    import crw_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int REC_BYTES = 32,
    localparam int ALIGN_BITS = $clog2(REC_BYTES),
    localparam int DATA_W     = 8 * REC_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_valid,
    output logic              cmp_ready,
    input  logic              cmp_req_rec,
    input  logic              cmp_addr_ok,
    input  logic [ADDR_W-1:0] cmp_addr,
    input  logic              cmp_has_result,
    input  logic [1:0]        cmp_outcome,
    input  logic [7:0]        cmp_result,
    input  logic [31:0]       cmp_bytes_done,
    input  logic [ADDR_W-1:0] cmp_fault_addr,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              swerr_valid,
    output logic [7:0]        swerr_code
);
    decision_t         dec;
    logic [DATA_W-1:0] image;
    logic              load;

    // Back-pressure: take a completion only when no write is pending.
    always_comb begin
        cmp_ready = !wr_valid;
        load      = cmp_valid && cmp_ready;
    end

    crw_decide #(.ALIGN_BITS(ALIGN_BITS)) u_decide (
        .req_rec    (cmp_req_rec),
        .addr_ok    (cmp_addr_ok),
        .addr_low   (cmp_addr[ALIGN_BITS-1:0]),
        .has_result (cmp_has_result),
        .outcome    (cmp_outcome),
        .dec        (dec)
    );

    crw_pack #(.ADDR_W(ADDR_W), .REC_BYTES(REC_BYTES)) u_pack (
        .status     (dec.code),
        .has_result (cmp_has_result),
        .result     (cmp_result),
        .bytes_done (cmp_bytes_done),
        .fault_addr (cmp_fault_addr),
        .image      (image)
    );

    crw_out #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .dec         (dec),
        .addr        (cmp_addr),
        .image       (image),
        .wr_ready    (wr_ready),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .swerr_valid (swerr_valid),
        .swerr_code  (swerr_code)
    );
endmodule

// File: rtl/cmpl_rec_writer_chk.sv
// Checker: port-level properties of the completion record writer, bound to
// every instance of the top module.
module cmpl_rec_writer_chk #(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmp_valid,
    input logic              cmp_ready,
    input logic              cmp_req_rec,
    input logic              cmp_addr_ok,
    input logic [ADDR_W-1:0] cmp_addr,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              swerr_valid
);
    // R8: pending write held stable until accepted
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    // R8: no completion taken while a write is pending
    a_r8_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !cmp_ready);

    // R6: issued writes always target an aligned address
    a_r6_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_addr[4:0] == 5'd0);

    // R4: no write when the address is not valid
    a_r4_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid && cmp_ready && !cmp_addr_ok |=> !wr_valid);

    // R1: requested record with aligned valid address is written next cycle
    a_r1_write: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid && cmp_ready && cmp_req_rec && cmp_addr_ok && cmp_addr[4:0] == 5'd0
        |=> wr_valid && !swerr_valid);

    // R10: a completion never yields both a write and a report
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid && cmp_ready |=> !(wr_valid && swerr_valid));
endmodule

bind cmpl_rec_writer cmpl_rec_writer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmp_valid   (cmp_valid),
    .cmp_ready   (cmp_ready),
    .cmp_req_rec (cmp_req_rec),
    .cmp_addr_ok (cmp_addr_ok),
    .cmp_addr    (cmp_addr),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .swerr_valid (swerr_valid)
);

// File: tb/cmpl_rec_writer_tb.sv
module cmpl_rec_writer_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmp_valid = 1'b0;
    logic         cmp_ready;
    logic         cmp_req_rec = 1'b0;
    logic         cmp_addr_ok = 1'b0;
    logic [63:0]  cmp_addr = '0;
    logic         cmp_has_result = 1'b0;
    logic [1:0]   cmp_outcome = 2'd0;
    logic [7:0]   cmp_result = '0;
    logic [31:0]  cmp_bytes_done = '0;
    logic [63:0]  cmp_fault_addr = '0;
    logic         wr_valid;
    logic         wr_ready = 1'b0;
    logic [63:0]  wr_addr;
    logic [255:0] wr_data;
    logic         swerr_valid;
    logic [7:0]   swerr_code;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    cmpl_rec_writer u_dut (.*);

    always #5 clk = ~clk;

    // Watchdog: counts as a failed check and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected record image built from the R7 layout.
    function automatic logic [255:0] rec(input logic [7:0] st, input logic hr,
                                         input logic [7:0] res, input logic [31:0] bd,
                                         input logic [63:0] fa);
        logic [255:0] r = '0;
        r[7:0]    = st;
        r[15:8]   = (st == 8'h01 && hr) ? res : 8'h00;
        r[63:32]  = bd;
        r[127:64] = (st == 8'h03) ? fa : 64'd0;
        return r;
    endfunction

    // One completion; checks the action, record and hold behaviour.
    task automatic run_case(input string tag, input logic req, input logic av,
                            input logic [63:0] addr, input logic hr, input logic [1:0] oc,
                            input logic [7:0] res, input logic [31:0] bd, input logic [63:0] fa,
                            input logic exp_w, input logic exp_e, input logic [7:0] code,
                            input int stall);
        @(negedge clk);
        cmp_valid = 1'b1; cmp_req_rec = req; cmp_addr_ok = av; cmp_addr = addr;
        cmp_has_result = hr; cmp_outcome = oc; cmp_result = res;
        cmp_bytes_done = bd; cmp_fault_addr = fa; wr_ready = 1'b0;
        @(negedge clk);
        cmp_valid = 1'b0;
        chk({tag, " R10 write"}, 256'(wr_valid), 256'(exp_w));
        chk({tag, " R10 report"}, 256'(swerr_valid), 256'(exp_e));
        if (exp_e) chk({tag, " report code"}, 256'(swerr_code), 256'(code));
        if (exp_w) begin
            chk({tag, " R1 addr"}, 256'(wr_addr), 256'(addr));
            chk({tag, " R7 image"}, wr_data, rec(code, hr, res, bd, fa));
            chk({tag, " R8 ready low"}, 256'(cmp_ready), 256'(0));
            // R8: offer a completion that would be reported; it must be refused
            cmp_valid = 1'b1; cmp_addr_ok = 1'b0; cmp_outcome = 2'd1;
            for (int i = 0; i < stall; i++) begin
                @(negedge clk);
                chk({tag, " R8 held"}, 256'(wr_valid), 256'(1));
                chk({tag, " R8 stable"}, wr_data, rec(code, hr, res, bd, fa));
                chk({tag, " R8 no report"}, 256'(swerr_valid), 256'(0));
            end
            cmp_valid = 1'b0;
            wr_ready = 1'b1;
            @(negedge clk);
            wr_ready = 1'b0;
            chk({tag, " R8 released"}, 256'(wr_valid), 256'(0));
            chk({tag, " R8 ready back"}, 256'(cmp_ready), 256'(1));
        end else begin
            @(negedge clk);
            chk({tag, " R10 pulse"}, 256'(swerr_valid), 256'(0));
            chk({tag, " no write"}, 256'(wr_valid), 256'(0));
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R9 wr_valid", 256'(wr_valid), 256'(0));
        chk("R9 swerr", 256'(swerr_valid), 256'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 ready", 256'(cmp_ready), 256'(1));
    endtask

    initial begin
        t_reset();
        run_case("R1 ok req",     1, 1, 64'h1000_0040, 0, 2'd0, 8'h00, 32'd512, 64'h0, 1, 0, 8'h01, 0);
        run_case("R1 ok result",  1, 1, 64'hABCD_0000, 1, 2'd0, 8'h5A, 32'd64,  64'h77, 1, 0, 8'h01, 3);
        run_case("R2 ok noreq",   0, 1, 64'h2000_0000, 0, 2'd0, 8'h00, 32'd8,   64'h0, 0, 0, 8'h00, 0);
        run_case("R3 fault",      0, 1, 64'h3000_0020, 0, 2'd1, 8'h11, 32'd4096, 64'hDEAD_BEE0, 1, 0, 8'h03, 2);
        run_case("R3 error",      0, 1, 64'h3000_0060, 0, 2'd2, 8'h00, 32'd100, 64'h1234, 1, 0, 8'h04, 0);
        run_case("R3 error3",     1, 1, 64'h3000_0080, 0, 2'd3, 8'h00, 32'd1,   64'h0, 1, 0, 8'h04, 0);
        run_case("R4 fault noad", 0, 0, 64'h0, 0, 2'd1, 8'h00, 32'd7, 64'h99, 0, 1, 8'h03, 0);
        run_case("R4 err noad",   1, 0, 64'h5, 0, 2'd2, 8'h00, 32'd7, 64'h99, 0, 1, 8'h04, 0);
        run_case("R4 ok noad",    1, 0, 64'h0, 0, 2'd0, 8'h00, 32'd7, 64'h0,  0, 0, 8'h00, 0);
        run_case("R5 noreq",      0, 1, 64'h4000_0000, 1, 2'd0, 8'h22, 32'd32, 64'h0, 1, 0, 8'h05, 0);
        run_case("R5 noaddr",     1, 0, 64'h0, 1, 2'd0, 8'h22, 32'd32, 64'h0, 0, 1, 8'h05, 0);
        run_case("R6 misalign",   1, 1, 64'h4000_0010, 0, 2'd0, 8'h00, 32'd32, 64'h0, 0, 1, 8'h06, 0);
        run_case("R6 misal flt",  0, 1, 64'h4000_0001, 0, 2'd1, 8'h00, 32'd32, 64'h3, 0, 1, 8'h06, 0);
        run_case("R7 fault fld",  1, 1, 64'hFFFF_FFE0, 1, 2'd1, 8'hEE, 32'hFFFF_FFFF, 64'hFFFF_0000_1111_2222, 1, 0, 8'h03, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule